// File: doc/BRIEF.md
# Inbound Address Window Decoder

This block sits on the inbound side of a bus bridge. It classifies every address that an external bus master presents. Software programs up to three memory windows and one I/O window through a small register port. Each window register packs an aligned bus-side base and a 4-bit logarithmic size code. The smallest window is 1 MB and the largest is 2 GB.

Each incoming request carries an address and a flag that says whether it is an I/O or a memory access. The block compares the address with the windows of the matching space. It reports whether a window hit and which one. It also returns the translated local address. The local side of every window starts at address zero, so the translated address is the offset of the request inside the window. The block moves no data.

Requests enter on a valid/ready stream and results leave on another valid/ready stream, with one register stage between them. A request is accepted on a clock edge where both in_valid and in_ready are high. Its result is held on the output until out_ready is high. in_ready is high whenever the output stage is empty or is being drained in that same cycle, so stalling the output stalls the input directly.

Top module: `inwin_decoder`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and in_ready is 1. Every window register reads back 0x000F0000, which is base 0 with size code 0xF, so every window is disabled.
- R2: A write with cfg_we set stores bits 31:16 of cfg_wdata into the register chosen by cfg_sel. Selects 0 to 2 choose memory windows 0 to 2 and select 3 chooses the I/O window. cfg_rdata shows the register chosen by cfg_sel, combinationally. Bits 15:0 always read as zero, because base bits below bit 20 and unused bits are discarded.
- R3: In a window register, bits 31:20 hold the base and bits 19:16 hold the size code c. For c from 0 to 11, the window spans 2^(20+c) bytes. An address hits the window when it equals the base in every bit from bit 20+c upward. Base bits below 20+c are ignored.
- R4: A window with a size code of 12 to 15 never hits.
- R5: For a memory request (in_io=0), only memory windows 0 to 2 are considered. If several of them hit, the lowest-numbered one wins, and out_idx reports its number.
- R6: On a hit, out_addr equals the request address modulo the size of the winning window. On a miss, out_hit, out_idx and out_addr are all 0.
- R7: An I/O request (in_io=1) is decoded only against the I/O window, and a hit reports out_idx=3. Memory windows never match I/O requests, and the I/O window never matches memory requests.
- R8: The result of a request accepted at one clock edge appears on the outputs, with out_valid set, right after the next clock edge.
- R9: While out_valid=1 and out_ready=0, in_ready is 0 and the output fields stay unchanged. When out_ready=1 and no new request is accepted, out_valid falls on the next edge.
- R10: A register write in the same cycle as a request acceptance does not affect that request. The request is decoded with the register values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0 to 2 memory windows, 3 I/O window |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the selected register |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | 32 | Bus-side request address |
| in_io | input | 1 | 1 for an I/O request, 0 for a memory request |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_hit | output | 1 | A window matched |
| out_idx | output | 2 | Matching window: 0 to 2 memory, 3 I/O |
| out_addr | output | 32 | Translated local address (offset inside the window) |

## Verification
A corrupted window register shows on cfg_rdata in the same cycle it is selected. It also shows in the hit, index or offset of the first request that touches the affected address bits, one cycle after that request is accepted. A priority or mask fault shows up at window edges: the first and last byte inside a window, and the bytes just outside it. The bench therefore probes every size code at those addresses, and it probes overlapping windows. A broken stall path shows up in the very next stalled cycle, as a changed output field or as in_ready rising.

// File: rtl/inwin_pkg.sv
package inwin_pkg;
  localparam int ADDR_W   = 32;
  localparam int BASE_LSB = 20;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 16;
  localparam int BASE_W   = ADDR_W - BASE_LSB;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
  } win_cfg_t;

  localparam win_cfg_t WIN_RESET = '{base: '0, code: '1};
endpackage

// File: rtl/inwin_regfile.sv
module inwin_regfile
  import inwin_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      sel,
  input  logic [ADDR_W-1:0]     wdata,
  output logic [ADDR_W-1:0]     rdata,
  output win_cfg_t [NREG-1:0]   cfg
);
  localparam int LOW_W = CODE_LSB;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[g] <= WIN_RESET;
      end else if (we && (int'(sel) == g)) begin
        cfg[g] <= win_cfg_t'(wdata[ADDR_W-1:CODE_LSB]);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (int'(sel) == i) rdata = {cfg[i], {LOW_W{1'b0}}};
    end
  end
endmodule

// File: rtl/inwin_match.sv
module inwin_match
  import inwin_pkg::*;
#(
  parameter int MAX_CODE = 11
) (
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam int SH_W = $clog2(ADDR_W + (1 << CODE_W));

  logic              legal;
  logic [SH_W-1:0]   shamt;
  logic [ADDR_W-1:0] upper_mask;
  logic [ADDR_W-1:0] base_full;

  always_comb begin
    legal      = (int'(cfg.code) <= MAX_CODE);
    shamt      = SH_W'(BASE_LSB) + SH_W'(cfg.code);
    upper_mask = {ADDR_W{1'b1}} << shamt;
    base_full  = {cfg.base, {BASE_LSB{1'b0}}};
    hit        = legal && (((addr ^ base_full) & upper_mask) == '0);
    offset     = addr & ~upper_mask;
  end
endmodule

// File: rtl/inwin_select.sv
module inwin_select
  import inwin_pkg::*;
#(
  parameter int NMEM  = 3,
  parameter int IDX_W = 2
) (
  input  logic [NMEM:0]             hits,
  input  logic [NMEM:0][ADDR_W-1:0] offsets,
  input  logic                      is_io,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx,
  output logic [ADDR_W-1:0]         addr
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    addr = '0;
    if (is_io) begin
      if (hits[NMEM]) begin
        hit  = 1'b1;
        idx  = IDX_W'(NMEM);
        addr = offsets[NMEM];
      end
    end else begin
      for (int i = NMEM - 1; i >= 0; i--) begin
        if (hits[i]) begin
          hit  = 1'b1;
          idx  = IDX_W'(i);
          addr = offsets[i];
        end
      end
    end
  end
endmodule

// File: rtl/inwin_decoder.sv
module inwin_decoder
  import inwin_pkg::*;
#(
  parameter int NMEM     = 3,
  parameter int MAX_CODE = 11,
  parameter int SEL_W    = $clog2(NMEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_io,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [SEL_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int NREG = NMEM + 1;

  win_cfg_t [NREG-1:0]           cfg;
  logic [NREG-1:0]               hits;
  logic [NREG-1:0][ADDR_W-1:0]   offsets;
  logic                          sel_hit;
  logic [SEL_W-1:0]              sel_idx;
  logic [ADDR_W-1:0]             sel_addr;

  inwin_regfile #(.NREG(NREG), .SEL_W(SEL_W)) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_win
    inwin_match #(.MAX_CODE(MAX_CODE)) match_i (
      .cfg    (cfg[g]),
      .addr   (in_addr),
      .hit    (hits[g]),
      .offset (offsets[g])
    );
  end

  inwin_select #(.NMEM(NMEM), .IDX_W(SEL_W)) sel_i (
    .hits    (hits),
    .offsets (offsets),
    .is_io   (in_io),
    .hit     (sel_hit),
    .idx     (sel_idx),
    .addr    (sel_addr)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit  <= sel_hit;
        out_idx  <= sel_idx;
        out_addr <= sel_addr;
      end
    end
  end
endmodule

// File: rtl/inwin_decoder_chk.sv
module inwin_decoder_chk #(
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic [SEL_W-1:0]  out_idx,
  input logic [ADDR_W-1:0] out_addr
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_idx) && $stable(out_addr)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_idx == '0 && out_addr == '0));
endmodule

bind inwin_decoder inwin_decoder_chk #(.SEL_W(SEL_W), .ADDR_W(inwin_pkg::ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_hit   (out_hit),
  .out_idx   (out_idx),
  .out_addr  (out_addr)
);

// File: tb/inwin_decoder_tb.sv
module inwin_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        in_io = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_hit;
  logic [1:0]  out_idx;
  logic [31:0] out_addr;

  int checks = 0;
  int fails = 0;
  logic [31:0] mreg [4];

  always #2 clk = ~clk;

  inwin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .in_io(in_io),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_idx(out_idx), .out_addr(out_addr)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [34:0] model(logic [31:0] a, logic io);
    logic [34:0] r = '0;
    for (int w = 3; w >= 0; w--) begin
      if ((io && w == 3) || (!io && w < 3)) begin
        int c = int'(mreg[w][19:16]);
        if (c <= 11) begin
          logic [31:0] m = 32'hFFFF_FFFF << (20 + c);
          if (((a ^ mreg[w]) & m) == 0) r = {1'b1, 2'(w), a & ~m};
        end
      end
    end
    return r;
  endfunction

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    mreg[sel] = d & 32'hFFFF_0000;
  endtask

  task automatic send(logic [31:0] a, logic io, string req);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_io = io;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk(req, 64'({out_hit, out_idx, out_addr}), 64'(model(a, io)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mreg[i] = 32'h000F_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    for (int s = 0; s < 4; s++) begin
      cfg_sel = 2'(s); #0.5;
      chk("R1 reset readback", 64'(cfg_rdata), 64'h000F_0000);
    end
    send(32'h0000_0000, 1'b0, "R1 disabled miss");

    // R2 readback with low bits dropped
    for (int s = 0; s < 4; s++) begin
      wr(s, 32'hFFFF_FFFF ^ 32'(s));
      cfg_sel = 2'(s); #0.5;
      chk("R2 readback", 64'(cfg_rdata), 64'(mreg[s]));
      wr(s, 32'h000F_0000);
    end

    // R3 R4 R6 R7: every window, every size code, edge addresses
    for (int w = 0; w < 4; w++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] base = 32'hA5A0_0000;
        logic [31:0] m = (c <= 11) ? (32'hFFFF_FFFF << (20 + c)) : 32'hFFF0_0000;
        logic [31:0] al = base & m;
        logic [31:0] sz = ~m + 1;
        wr(w, base | (32'(c) << 16) | 32'h0000_BEEF);
        send(al, w == 3, "R3 first byte");
        send(al + sz - 1, w == 3, "R3 last byte");
        send(al + sz, w == 3, "R3 above window");
        send(al - 1, w == 3, "R3 below window");
        send(al + (sz >> 1) + 32'h123, w == 3, "R6 mid offset");
        send(al, w != 3, "R7 wrong space");
        if (c >= 12) send(32'h0000_0000, w == 3, "R4 illegal code");
        wr(w, 32'h000F_0000);
      end
    end

    // R5 overlapping windows
    wr(0, 32'h1000_0000 | (32'h3 << 16));
    wr(1, 32'h1000_0000 | (32'h8 << 16));
    wr(2, 32'h0000_0000 | (32'hB << 16));
    wr(3, 32'h1000_0000 | (32'h0 << 16));
    for (int k = 0; k < 24; k++) begin
      logic [31:0] a = 32'h0F00_0000 + 32'(k) * 32'h0098_7000;
      send(a, 1'b0, "R5 priority");
      send(a, 1'b1, "R7 io only");
    end
    send(32'h8000_0000, 1'b0, "R5 beyond all");

    // R10 write in same cycle as accept
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h1000_0040; in_io = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h000F_0000;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    chk("R10 old config", 64'({out_hit, out_idx, out_addr}), 64'({1'b1, 2'd0, 32'h0000_0040}));
    mreg[0] = 32'h000F_0000;
    send(32'h1000_0040, 1'b0, "R10 new config");

    // R8 R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h1234_5678; in_io = 1'b0;
    @(negedge clk);
    chk("R8 valid after one edge", 64'(out_valid), 64'd1);
    chk("R8 result", 64'({out_hit, out_idx, out_addr}), 64'(model(32'h1234_5678, 1'b0)));
    in_addr = 32'h0000_1000;
    for (int k = 0; k < 3; k++) begin
      chk("R9 in_ready low", 64'(in_ready), 64'd0);
      @(negedge clk);
      chk("R9 held", 64'({out_valid, out_hit, out_idx, out_addr}),
          64'({1'b1, model(32'h1234_5678, 1'b0)}));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next result", 64'({out_valid, out_hit, out_idx, out_addr}),
        64'({1'b1, model(32'h0000_1000, 1'b0)}));
    @(negedge clk);
    chk("R9 drained", 64'(out_valid), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule